// File: doc/BRIEF.md
# Alarm Match and Interrupt Status Unit

This unit sits beside a time-of-day counter. It holds three alarm bytes, for seconds, minutes and hours, that a host writes over a small register bus. On every update-complete pulse from the counter it compares the current time fields against those bytes. A full match raises an alarm flag.

The same pulse raises an update flag, and a periodic tick input raises a periodic flag. The three flags sit in a status byte that the host reads. Reading it clears every flag.

An active-high interrupt request is driven whenever a flag is set and its enable bit is high. Keeping time is not part of this unit.

Top module: `alm_irq_unit`

## Requirements
- R1: After reset, the three alarm bytes read 0x00, the status byte reads 0x00 and `irq_o` is low.
- R2: A write at bus address 0, 1 or 2 stores the byte into the seconds, minutes or hours alarm. A read at the same address returns it in the same cycle.
- R3: An alarm byte whose bits 7 and 6 are both 1 matches any value of its time field.
- R4: The hours alarm is compared with all eight bits, including the PM flag in bit 7. Hours that differ only in bit 7 do not raise the alarm flag.
- R5: The comparison takes effect only in a cycle with `upd_done_i` high. A matching time with no pulse leaves the alarm flag clear.
- R6: Each event sets its own status bit in the cycle after it occurs. `upd_done_i` sets bit 4 (update). `per_tick_i` sets bit 6 (periodic). A match on an update pulse sets bit 5 (alarm).
- R7: A read at address 3 returns the status byte and clears all flags on the next clock edge. An event in the same cycle as the read is kept for the next read.
- R8: Status bit 7 is high when any flag is set whose enable is high. The enable inputs are `int_en_i[2]` for the periodic flag, `int_en_i[1]` for the alarm flag and `int_en_i[0]` for the update flag. Unused status bits 3..0 read as 0.
- R9: `irq_o` equals status bit 7 at all times. It drops after the read that clears the flags.
- R10: Rewriting an alarm byte never sets or clears a flag. The flags change only through events and status reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sec_i | input | 8 | Current seconds field |
| min_i | input | 8 | Current minutes field |
| hr_i | input | 8 | Current hours field, bit 7 = PM |
| upd_done_i | input | 1 | One-cycle update-complete pulse |
| per_tick_i | input | 1 | One-cycle periodic event |
| int_en_i | input | 3 | Enables: [2] periodic, [1] alarm, [0] update |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bound checker covers four behaviours on every cycle:
- each update and periodic pulse leaves its flag set;
- the alarm flag never rises without an update pulse;
- a quiet cycle holds the flags steady, and a lone status read empties them;
- the request line is never high with no flag set.

Some behaviours only the bench's scenarios can show: the wildcard match, the AM/PM distinction in the hours compare, and the exact status byte values under each enable setting. The same holds for keeping an event that arrives during a read, and for flags surviving an alarm rewrite.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 2;
    localparam int unsigned N_FLD  = 3;

    localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

    localparam int unsigned SB_IRQ = 7;
    localparam int unsigned SB_PER = 6;
    localparam int unsigned SB_ALM = 5;
    localparam int unsigned SB_UPD = 4;

    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } flags_t;
endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] target_i,
    input  logic [W-1:0] cur_i,
    output logic         hit_o
);
    logic any_w;

    always_comb begin
        any_w = &target_i[W-1:W-2];
        hit_o = any_w | (target_i == cur_i);
    end
endmodule

// File: rtl/alm_regfile.sv
module alm_regfile #(
    parameter int unsigned W  = 8,
    parameter int unsigned N  = 3,
    parameter int unsigned AW = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [AW-1:0]       addr_i,
    input  logic [W-1:0]        wdata_i,
    output logic [N-1:0][W-1:0] alarm_o
);
    typedef struct packed {
        logic [N-1:0][W-1:0] slot;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        for (int i = 0; i < N; i++) begin
            if (wr_en_i && (int'(addr_i) == i)) begin
                rf_d.slot[i] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) rf_q <= '0;
        else         rf_q <= rf_d;
    end

    assign alarm_o = rf_q.slot;
endmodule

// File: rtl/alm_irq_unit.sv
module alm_irq_unit
    import alm_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [W-1:0]  sec_i,
    input  logic [W-1:0]  min_i,
    input  logic [W-1:0]  hr_i,
    input  logic          upd_done_i,
    input  logic          per_tick_i,
    input  logic [2:0]    int_en_i,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  rdata_o,
    output logic          irq_o
);
    localparam int unsigned NF = N_FLD;

    logic [NF-1:0][W-1:0] alarm_w;
    logic [NF-1:0][W-1:0] cur_w;
    logic [NF-1:0]        hit_w;
    logic                 alm_ev_w;
    logic                 rd_stat_w;
    logic                 irqf_w;
    logic [W-1:0]         stat_w;

    flags_t st_d, st_q;

    alm_regfile #(.W(W), .N(NF), .AW(AW)) u_rf (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .alarm_o (alarm_w)
    );

    assign cur_w = {hr_i, min_i, sec_i};

    for (genvar g = 0; g < NF; g++) begin : g_cmp
        alm_field_cmp #(.W(W)) u_cmp (
            .target_i (alarm_w[g]),
            .cur_i    (cur_w[g]),
            .hit_o    (hit_w[g])
        );
    end

    always_comb begin
        alm_ev_w  = upd_done_i & (&hit_w);
        rd_stat_w = rd_en_i & (addr_i == A_STAT);

        st_d = st_q;
        if (rd_stat_w)  st_d = '0;
        if (per_tick_i) st_d.per = 1'b1;
        if (upd_done_i) st_d.upd = 1'b1;
        if (alm_ev_w)   st_d.alm = 1'b1;

        irqf_w = (st_q.per & int_en_i[2]) |
                 (st_q.alm & int_en_i[1]) |
                 (st_q.upd & int_en_i[0]);

        stat_w         = '0;
        stat_w[SB_IRQ] = irqf_w;
        stat_w[SB_PER] = st_q.per;
        stat_w[SB_ALM] = st_q.alm;
        stat_w[SB_UPD] = st_q.upd;

        if (addr_i == A_STAT) rdata_o = stat_w;
        else if (int'(addr_i) < NF) rdata_o = alarm_w[addr_i];
        else rdata_o = '0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o = irqf_w;
endmodule

// File: rtl/alm_irq_chk.sv
module alm_irq_chk
    import alm_pkg::*;
#(
    parameter int unsigned AW = ADDR_W
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          upd_done_i,
    input logic          per_tick_i,
    input logic          rd_en_i,
    input logic [AW-1:0] addr_i,
    input logic          irq_o,
    input flags_t        flags_i
);
    logic rd_stat;
    assign rd_stat = rd_en_i && (addr_i == A_STAT);

    p_upd_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_done_i |=> flags_i.upd);

    p_per_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        per_tick_i |=> flags_i.per);

    p_no_alm_wo_upd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!upd_done_i && !flags_i.alm) |=> !flags_i.alm);

    p_read_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_stat && !upd_done_i && !per_tick_i) |=> (flags_i == '0));

    p_hold_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rd_stat && !upd_done_i && !per_tick_i) |=> $stable(flags_i));

    p_irq_needs_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (flags_i != '0));
endmodule

bind alm_irq_unit alm_irq_chk #(.AW(AW)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_done_i (upd_done_i),
    .per_tick_i (per_tick_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .irq_o      (irq_o),
    .flags_i    (st_q)
);

// File: tb/sim_alm_irq_unit.sv
module sim_alm_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sec = '0, mn = '0, hr = '0;
    logic       upd = 1'b0, per = 1'b0;
    logic [2:0] en = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    alm_irq_unit u0 (
        .clk_i(clk), .rst_ni(rst_n), .sec_i(sec), .min_i(mn), .hr_i(hr),
        .upd_done_i(upd), .per_tick_i(per), .int_en_i(en),
        .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    // monitor: compares each read against the queued expectation
    always @(negedge clk) begin
        if (rd && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_run++;
            if (rdata !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %02h exp %02h", it.tag, rdata, it.exp);
            end
        end
    end

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk);
        n_run++;
        if (irq !== exp) begin
            n_fail++;
            $display("FAIL %s: irq got %0b exp %0b", tag, irq, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        @(posedge clk); #1;
        sb_q.push_back(it);
        rd = 1'b1; addr = a;
        @(posedge clk); #1;
        rd = 1'b0;
    endtask

    task automatic pulse_upd();
        @(posedge clk); #1; upd = 1'b1;
        @(posedge clk); #1; upd = 1'b0;
    endtask

    task automatic pulse_per();
        @(posedge clk); #1; per = 1'b1;
        @(posedge clk); #1; per = 1'b0;
    endtask

    initial begin
        #(8 * 50000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk_irq(1'b0, "R1 irq");
        rd_reg(2'd3, 8'h00, "R1 status");
        rd_reg(2'd0, 8'h00, "R1 sec alarm");
        rd_reg(2'd2, 8'h00, "R1 hr alarm");
        // R2 write / readback
        wr_reg(2'd0, 8'h30);
        wr_reg(2'd1, 8'hC5);
        wr_reg(2'd2, 8'h82);
        rd_reg(2'd0, 8'h30, "R2 sec");
        rd_reg(2'd1, 8'hC5, "R2 min");
        rd_reg(2'd2, 8'h82, "R2 hr");
        // R5 matching time without an update pulse
        sec = 8'h30; mn = 8'h12; hr = 8'h82;
        repeat (4) @(posedge clk);
        rd_reg(2'd3, 8'h00, "R5 no pulse");
        // R3 wildcard minutes, R6 flags on update
        pulse_upd();
        rd_reg(2'd3, 8'h30, "R3 R6 alarm+update");
        rd_reg(2'd3, 8'h00, "R7 cleared");
        // R4 hours differ only in PM bit
        hr = 8'h02;
        pulse_upd();
        rd_reg(2'd3, 8'h10, "R4 am/pm mismatch");
        // R3 all wildcards with arbitrary time
        wr_reg(2'd0, 8'hFF); wr_reg(2'd2, 8'hC0);
        sec = 8'h47; hr = 8'h11;
        pulse_upd();
        rd_reg(2'd3, 8'h30, "R3 all wildcard");
        // R6 periodic, R8 R9 with periodic enable
        en = 3'b100;
        pulse_per();
        chk_irq(1'b1, "R9 irq on periodic");
        rd_reg(2'd3, 8'hC0, "R8 periodic enabled");
        chk_irq(1'b0, "R9 irq after clear");
        // R8 alarm enable only, update flag only
        en = 3'b010;
        wr_reg(2'd2, 8'h05);
        pulse_upd();
        chk_irq(1'b0, "R8 update not enabled");
        rd_reg(2'd3, 8'h10, "R8 update only");
        // R7 event in the same cycle as the read
        @(posedge clk); #1;
        begin
            item_t it;
            it.exp = 8'h00; it.tag = "R7 read during event";
            sb_q.push_back(it);
        end
        rd = 1'b1; addr = 2'd3; per = 1'b1;
        @(posedge clk); #1;
        rd = 1'b0; per = 1'b0;
        rd_reg(2'd3, 8'h40, "R7 event kept");
        // R10 rewriting alarm after a match keeps the flag
        wr_reg(2'd2, 8'h11);
        pulse_upd();
        wr_reg(2'd2, 8'h03);
        chk_irq(1'b1, "R10 irq held");
        rd_reg(2'd3, 8'hB0, "R10 flag survives rewrite");
        // R10 alarm moved onto current time without a pulse
        wr_reg(2'd2, 8'h11);
        repeat (3) @(posedge clk);
        rd_reg(2'd3, 8'h00, "R10 no flag from write");
        chk_irq(1'b0, "R10 irq low");
        repeat (2) @(posedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule